// File: doc/BRIEF.md
# Write Downsizer, 32-bit Master to 16-bit Slave

This block sits on the write path of a bus bridge. A 32-bit master side presents one write at a time: an address, a size code (byte, halfword or word), 32 bits of write data and a 4-bit byte strobe. The block works out which byte lanes the address and size make valid and checks the strobe against those lanes. It then replays the write as one or two beats on a 16-bit slave side, each beat carrying a 2-bit strobe.

The master is stalled through its ready output while the slave beats are outstanding. A write whose strobe leaves a valid lane unset, or whose address is not aligned to its size, produces no slave beat. It is answered with a two-cycle error response instead. Incrementing bursts are handled as a series of independent single writes.

A master write is taken on a rising clock edge at which `m_valid` and `m_ready` are both high. A slave beat completes on a rising edge at which `s_valid` and `s_ready` are both high.

Top module: `ahb_wr_downsizer`

## Requirements
- R1: After reset, `m_ready` is 1 and `s_valid` and `m_err` are 0.
- R2: Valid master lanes depend on `m_size` and `m_addr[1:0]`, with lane k covering bits 8k+7..8k. Size code 0 (byte) marks only lane `m_addr[1:0]`. Size code 1 (halfword) marks lanes 0,1 when `m_addr[1]`=0 and lanes 2,3 when it is 1. Size code 2 (word) marks all four lanes.
- R3: A byte or halfword write produces one slave beat. Its `s_addr` is `m_addr` with bit 0 cleared. Its `s_wdata` is `m_wdata[15:0]` when `m_addr[1]`=0 and `m_wdata[31:16]` when it is 1.
- R4: A word write produces two slave beats. The first goes to `m_addr` and carries `m_wdata[15:0]`. The second goes to `m_addr`+2 and carries `m_wdata[31:16]`.
- R5: Each beat's `s_wstrb` is the matching half of `m_wstrb` (bits 1:0 for the low half, bits 3:2 for the high half) with lanes that are not valid forced to 0. Strobe bits on lanes that are not valid are otherwise ignored.
- R6: A write whose strobe is 0 on any valid lane is an error and produces no slave beat.
- R7: A halfword at an odd address, a word at an address that is not a multiple of 4, and size code 3 are errors that produce no slave beat.
- R8: On an error, the cycle after acceptance shows `m_err`=1 with `m_ready`=0. The cycle after that shows `m_err`=1 with `m_ready`=1, and a write presented in that cycle is accepted normally.
- R9: `m_ready` is 0 from the cycle after a good write is accepted until the edge that completes its last slave beat. It is 1 in the cycle after that edge.
- R10: While `s_ready` is 0, a pending beat keeps `s_valid` high and its address, data and strobe unchanged.
- R11: `m_valid` and the other master inputs are ignored while `m_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 1 | Master write request |
| m_addr | input | ADDR_W | Master byte address |
| m_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| m_wdata | input | 32 | Master write data |
| m_wstrb | input | 4 | Master byte strobes |
| m_ready | output | 1 | Master may present a write (low = stall) |
| m_err | output | 1 | Error response to the master |
| s_valid | output | 1 | Slave beat pending |
| s_addr | output | ADDR_W | Slave beat byte address (even) |
| s_wdata | output | 16 | Slave beat data |
| s_wstrb | output | 2 | Slave beat byte strobes |
| s_ready | input | 1 | Slave accepts the beat |

## Verification
The hardest case to reach from the ports is a new write presented in the second cycle of an error response, since the master must drive it in a cycle where `m_err` is still high. Directed sequences place a good write right after a strobe error and right after a misalignment error, and check both the error timing and the beats of the follow-on write. Random traffic supplies the rest. It covers every size and offset, strobes with spare inactive bits set, randomly dropped valid strobes, random slave stalls, and junk master requests driven during every stall.

// File: rtl/ahb_wdn_pkg.sv
package ahb_wdn_pkg;
  localparam int M_LANES = 4;
  localparam int S_LANES = 2;
  localparam int M_DW    = 8 * M_LANES;
  localparam int S_DW    = 8 * S_LANES;
  localparam int SZ_W    = 2;

  localparam logic [SZ_W-1:0] SZ_BYTE = 2'd0;
  localparam logic [SZ_W-1:0] SZ_HALF = 2'd1;
  localparam logic [SZ_W-1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_ERR1 = 2'd2,
    ST_ERR2 = 2'd3
  } seq_st_e;
endpackage

// File: rtl/ahb_wdn_rst_sync.sv
module ahb_wdn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ahb_wdn_lane_check.sv
module ahb_wdn_lane_check
  import ahb_wdn_pkg::*;
(
  input  logic [1:0]         addr_lo,
  input  logic [SZ_W-1:0]    size,
  input  logic [M_LANES-1:0] strb,
  output logic [M_LANES-1:0] lane_mask,
  output logic               misalign,
  output logic               strb_err
);
  for (genvar i = 0; i < M_LANES; i++) begin : g_lane
    localparam logic [1:0] LI = 2'(i);
    assign lane_mask[i] = (size == SZ_WORD)
                        | ((size == SZ_HALF) & (addr_lo[1] == LI[1]))
                        | ((size == SZ_BYTE) & (addr_lo == LI));
  end

  assign misalign = (size == 2'd3)
                  | ((size == SZ_HALF) & addr_lo[0])
                  | ((size == SZ_WORD) & (addr_lo != 2'd0));

  assign strb_err = |(lane_mask & ~strb);
endmodule

// File: rtl/ahb_wdn_seq.sv
module ahb_wdn_seq
  import ahb_wdn_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               m_valid,
  input  logic [ADDR_W-1:1]  m_addr_hi,
  input  logic [SZ_W-1:0]    m_size,
  input  logic [M_DW-1:0]    m_wdata,
  input  logic [M_LANES-1:0] m_wstrb,
  input  logic [M_LANES-1:0] lane_mask,
  input  logic               bad_xfer,
  output logic               m_ready,
  output logic               m_err,
  output logic               s_valid,
  output logic [ADDR_W-1:0]  s_addr,
  output logic [S_DW-1:0]    s_wdata,
  output logic [S_LANES-1:0] s_wstrb,
  input  logic               s_ready
);
  seq_st_e              st_q, st_d;
  logic                 load_en, adv_en, accept;
  logic [ADDR_W-1:0]    addr_q;
  logic [M_DW-1:0]      data_q;
  logic [M_LANES-1:0]   strb_q;
  logic                 hi_q, last_q;

  assign m_ready = (st_q == ST_IDLE) | (st_q == ST_ERR2);
  assign m_err   = (st_q == ST_ERR1) | (st_q == ST_ERR2);
  assign s_valid = (st_q == ST_BEAT);
  assign accept  = m_valid & m_ready;

  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    adv_en  = 1'b0;
    case (st_q)
      ST_IDLE, ST_ERR2: begin
        if (accept) begin
          st_d    = bad_xfer ? ST_ERR1 : ST_BEAT;
          load_en = ~bad_xfer;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_BEAT: begin
        if (s_ready) begin
          if (last_q) st_d = ST_IDLE;
          else        adv_en = 1'b1;
        end
      end
      ST_ERR1: st_d = ST_ERR2;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '0;
      hi_q   <= 1'b0;
      last_q <= 1'b0;
    end else if (load_en) begin
      addr_q <= {m_addr_hi, 1'b0};
      data_q <= m_wdata;
      strb_q <= m_wstrb & lane_mask;
      hi_q   <= m_addr_hi[1];
      last_q <= (m_size != SZ_WORD);
    end else if (adv_en) begin
      addr_q <= addr_q + ADDR_W'(2);
      hi_q   <= 1'b1;
      last_q <= 1'b1;
    end
  end

  assign s_addr  = addr_q;
  assign s_wdata = hi_q ? data_q[M_DW-1 -: S_DW] : data_q[S_DW-1:0];
  assign s_wstrb = hi_q ? strb_q[M_LANES-1 -: S_LANES] : strb_q[S_LANES-1:0];

  p_stall_while_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> !m_ready);
  p_err_second_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_err && !m_ready) |=> (m_err && m_ready));
  p_no_beat_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> !s_valid);
  p_hold_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_addr) && $stable(s_wdata) && $stable(s_wstrb)));
  p_upper_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !last_q) |=> (s_valid && s_addr == $past(s_addr) + ADDR_W'(2)));
  p_even_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> !s_addr[0]);
  p_strobe_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> (s_wstrb != '0));
endmodule

// File: rtl/ahb_wr_downsizer.sv
module ahb_wr_downsizer
  import ahb_wdn_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               m_valid,
  input  logic [ADDR_W-1:0]  m_addr,
  input  logic [SZ_W-1:0]    m_size,
  input  logic [M_DW-1:0]    m_wdata,
  input  logic [M_LANES-1:0] m_wstrb,
  output logic               m_ready,
  output logic               m_err,
  output logic               s_valid,
  output logic [ADDR_W-1:0]  s_addr,
  output logic [S_DW-1:0]    s_wdata,
  output logic [S_LANES-1:0] s_wstrb,
  input  logic               s_ready
);
  logic               rst_n_sync;
  logic [M_LANES-1:0] lane_mask;
  logic               misalign, strb_err;

  ahb_wdn_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ahb_wdn_lane_check lane_check_i (
    .addr_lo   (m_addr[1:0]),
    .size      (m_size),
    .strb      (m_wstrb),
    .lane_mask (lane_mask),
    .misalign  (misalign),
    .strb_err  (strb_err)
  );

  ahb_wdn_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .m_valid   (m_valid),
    .m_addr_hi (m_addr[ADDR_W-1:1]),
    .m_size    (m_size),
    .m_wdata   (m_wdata),
    .m_wstrb   (m_wstrb),
    .lane_mask (lane_mask),
    .bad_xfer  (misalign | strb_err),
    .m_ready   (m_ready),
    .m_err     (m_err),
    .s_valid   (s_valid),
    .s_addr    (s_addr),
    .s_wdata   (s_wdata),
    .s_wstrb   (s_wstrb),
    .s_ready   (s_ready)
  );
endmodule

// File: tb/ahb_wr_downsizer_tb_top.sv
module ahb_wr_downsizer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_valid;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic [3:0]  m_wstrb;
  logic        m_ready, m_err, s_valid, s_ready;
  logic [31:0] s_addr;
  logic [15:0] s_wdata;
  logic [1:0]  s_wstrb;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ahb_wr_downsizer #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_ready(m_ready), .m_err(m_err),
    .s_valid(s_valid), .s_addr(s_addr), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_ready(s_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes(input logic [31:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001 << a[1:0];
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      2'd2:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic void model(input logic [31:0] a, input logic [1:0] sz,
      input logic [31:0] d, input logic [3:0] st, output bit e, output bit mis,
      output int n, output logic [1:0][31:0] ba, output logic [1:0][15:0] bd,
      output logic [1:0][1:0] bs);
    logic [3:0] mk;
    mk  = lanes(a, sz);
    mis = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0);
    e   = mis || ((mk & ~st) != 4'd0);
    ba = '0; bd = '0; bs = '0;
    if (sz == 2'd2) begin
      n = 2;
      ba[0] = a;       bd[0] = d[15:0];  bs[0] = st[1:0];
      ba[1] = a + 32'd2; bd[1] = d[31:16]; bs[1] = st[3:2];
    end else begin
      n = 1;
      ba[0] = {a[31:1], 1'b0};
      bd[0] = a[1] ? d[31:16] : d[15:0];
      bs[0] = a[1] ? (st[3:2] & mk[3:2]) : (st[1:0] & mk[1:0]);
    end
  endfunction

  // Called at a negedge where m_ready is expected high; returns at a negedge.
  task automatic xfer(input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic [3:0] st, input int stall_pct);
    bit e, mis, prev_stall, prev_junk;
    int n, idx;
    logic [1:0][31:0] ba;
    logic [1:0][15:0] bd;
    logic [1:0][1:0]  bs;
    model(a, sz, d, st, e, mis, n, ba, bd, bs);
    m_valid = 1'b1; m_addr = a; m_size = sz; m_wdata = d; m_wstrb = st;
    @(negedge clk);
    if (e) begin
      m_valid = 1'b0;
      chk(m_err && !m_ready && !s_valid, mis ? "R7" : "R6", "err cycle1 {err,rdy,sv}",
          {29'd0, m_err, m_ready, s_valid}, 32'd4);
      @(negedge clk);
      chk(m_err && m_ready && !s_valid, "R8", "err cycle2 {err,rdy,sv}",
          {29'd0, m_err, m_ready, s_valid}, 32'd6);
      return;
    end
    idx = 0; prev_stall = 0; prev_junk = 0;
    for (int cyc = 0; cyc < 60; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (prev_stall)
        chk(s_valid, "R10", "beat dropped during stall", {31'd0, s_valid}, 32'd1);
      if (m_ready) begin
        chk(idx == n && !s_valid, "R9", "beats done when ready returns", idx, n);
        m_valid = 1'b0;
        return;
      end
      chk(!m_err, "R6", "unexpected err", {31'd0, m_err}, 32'd0);
      if (s_valid) begin
        if (idx >= n) begin
          chk(0, "R9", "extra beat", idx, n);
        end else begin
          chk(s_addr == ba[idx], (sz == 2'd2) ? "R4" : "R3", "s_addr", s_addr, ba[idx]);
          chk(s_wdata == bd[idx], (sz == 2'd2) ? "R4" : "R3", "s_wdata", {16'd0, s_wdata}, {16'd0, bd[idx]});
          chk(s_wstrb == bs[idx], "R5", "s_wstrb", {30'd0, s_wstrb}, {30'd0, bs[idx]});
          if (prev_junk)
            chk(s_addr == ba[idx], "R11", "junk request disturbed beat", s_addr, ba[idx]);
        end
      end
      s_ready = (int'($urandom % 100) >= stall_pct);
      prev_stall = s_valid && !s_ready;
      if (s_valid && s_ready) idx++;
      m_valid = $urandom % 2; m_addr = $urandom; m_size = 2'($urandom);
      m_wdata = $urandom; m_wstrb = 4'($urandom);
      prev_junk = m_valid;
    end
    chk(0, "R9", "m_ready never returned", 0, 1);
    m_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; m_valid = 1'b0; m_addr = '0; m_size = '0; m_wdata = '0;
    m_wstrb = '0; s_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(m_ready && !s_valid && !m_err, "R1", "reset {rdy,sv,err}",
        {29'd0, m_ready, s_valid, m_err}, 32'd4);

    // R2/R5 byte lanes; inactive strobe bits set and ignored
    xfer(32'h100, 2'd0, 32'hA1B2C3D4, 4'b0001, 0);
    xfer(32'h101, 2'd0, 32'hA1B2C3D4, 4'b1111, 0);
    xfer(32'h102, 2'd0, 32'hA1B2C3D4, 4'b1101, 30);
    xfer(32'h103, 2'd0, 32'hA1B2C3D4, 4'b1000, 0);
    // R2: byte at offset 1 with lane 1 strobe missing -> error
    xfer(32'h101, 2'd0, 32'h11223344, 4'b1101, 0);
    chk(!m_err || m_ready, "R2", "lane 1 error seen", {31'd0, m_err}, 32'd1);
    // R8: write presented in the second error cycle is taken
    xfer(32'h200, 2'd2, 32'hDEADBEEF, 4'b1111, 50);
    // R7 misaligned halfword, then follow-on write in error cycle 2
    xfer(32'h301, 2'd1, 32'h0, 4'b0011, 0);
    xfer(32'h302, 2'd1, 32'hCAFEF00D, 4'b1100, 0);
    // R7 misaligned word and size code 3
    xfer(32'h402, 2'd2, 32'h0, 4'b1111, 0);
    xfer(32'h400, 2'd3, 32'h0, 4'b1111, 0);
    // R6 word missing one lane
    xfer(32'h500, 2'd2, 32'h12345678, 4'b1110, 0);
    // R10/R11 heavy stalls on a word
    xfer(32'h600, 2'd2, 32'h89ABCDEF, 4'b1111, 80);
    @(negedge clk);

    for (int k = 0; k < 400; k++) begin
      logic [1:0]  sz;
      logic [31:0] a;
      logic [3:0]  st;
      sz = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
      a  = $urandom;
      if ($urandom % 5 != 0) begin
        if (sz == 2'd1) a[0] = 1'b0;
        if (sz == 2'd2) a[1:0] = 2'b00;
      end
      st = ($urandom % 6 == 0) ? 4'($urandom) : (lanes(a, sz) | 4'($urandom));
      xfer(a, sz, $urandom, st, 25);
    end
    repeat (3) @(negedge clk);
    chk(m_ready && !s_valid && !m_err, "R9", "idle at end {rdy,sv,err}",
        {29'd0, m_ready, s_valid, m_err}, 32'd4);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule